// File: doc/BRIEF.md
# Segmented Converter Code Encoder and 2:1 Serializer

This block is the last digital stage in front of a segmented current-steering converter. On every rising edge of a slow clock it takes two 8-bit samples, an even one and an odd one, which the equalizer has produced in parallel. Each sample is first turned from signed two's-complement into offset binary. It is then split into two parts. The upper three bits become seven unary lines that drive equal-weight current cells. The lower five bits stay binary and drive weighted cells.

Both encoded words are registered in the slow domain. A 2:1 multiplexer clocked at twice the slow rate then interleaves them into one double-rate stream. The even word occupies the first fast cycle of a slow period and the odd word the second. The fast clock must be exactly twice the slow clock, with rising edges aligned. The block finds the slow-period phase by itself, so no extra select line is needed.

Top module: `dac_seg_serializer`

## Requirements
- R1: While `rst_n` is low, `therm_out` and `bin_out` are all zero.
- R2: With `SIGNED_IN` = 1 (default), each input code is turned into offset binary by inverting bit 7. So 0x00 maps to 0x80, 0x80 maps to 0x00, 0x7F maps to 0xFF and 0xFF maps to 0x7F.
- R3: `therm_out[i]` (i = 0..6) is high exactly when the value of offset bits [7:5] is greater than i. The high lines therefore always fill up from bit 0 with no gaps.
- R4: `bin_out` equals bits [4:0] of the offset code of the word on the output.
- R5: For every output word, 32 times the number of high thermometer lines plus `bin_out` reconstructs the full 8-bit offset code.
- R6: Within each slow period, the even sample's word is output in the fast cycle that begins at the slow rising edge, and the odd sample's word in the fast cycle that follows.
- R7: The pair sampled at slow rising edge n appears on the output starting at slow rising edge n+2, and each word stays for exactly one fast cycle.
- R8: With `SIGNED_IN` = 0, the input code is already offset binary and is segmented unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock; samples the input pair |
| clk_fast | input | 1 | Clock at twice the slow rate, rising edges aligned with clk_slow |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |
| even_code | input | 8 | Even sample of the pair |
| odd_code | input | 8 | Odd sample of the pair |
| therm_out | output | 7 | Unary lines for the upper segment |
| bin_out | output | 5 | Binary lower segment |

## Verification
A wrong phase decision in the fast domain swaps the even and odd words, or repeats one of them. This shows up in the very first fast cycle after the encoded words change, as soon as the two lanes carry different codes. A stale or half-updated encoding register shows as an output word that matches the pair from the wrong slow period. Because every check is tied to a fixed latency of two slow periods, such an error appears within three slow periods. Encoding faults, such as a missed sign inversion, a thermometer line with the wrong threshold or a lost binary bit, break the reconstruction of the offset code. Sweeping all 256 codes on each lane exposes these on the first code that uses the faulty bit.

// File: rtl/dac_seg_serializer.sv
module dac_seg_serializer #(
  parameter int CODE_W     = 8,
  parameter int UNARY_BITS = 3,
  parameter bit SIGNED_IN  = 1'b1
) (
  input  logic                              clk_slow,
  input  logic                              clk_fast,
  input  logic                              rst_n,
  input  logic [CODE_W-1:0]                 even_code,
  input  logic [CODE_W-1:0]                 odd_code,
  output logic [(1<<UNARY_BITS)-2:0]        therm_out,
  output logic [CODE_W-UNARY_BITS-1:0]      bin_out
);

  localparam int BIN_W   = CODE_W - UNARY_BITS;
  localparam int THERM_W = (1 << UNARY_BITS) - 1;
  localparam int WORD_W  = THERM_W + BIN_W;

  function automatic logic [WORD_W-1:0] seg_encode(input logic [CODE_W-1:0] c);
    logic [UNARY_BITS-1:0] m;
    logic [THERM_W-1:0]    t;
    m = c[CODE_W-1 -: UNARY_BITS];
    for (int i = 0; i < THERM_W; i++) t[i] = (int'(m) > i);
    return {t, c[BIN_W-1:0]};
  endfunction

  logic [CODE_W-1:0] even_q, odd_q, even_off, odd_off;
  logic [WORD_W-1:0] enc_even, enc_odd, odd_hold, out_word;
  logic              tog, tog_q, mid;

  // R2 / R8: input format variant
  generate
    if (SIGNED_IN) begin : g_signed
      assign even_off = {~even_q[CODE_W-1], even_q[CODE_W-2:0]};
      assign odd_off  = {~odd_q[CODE_W-1],  odd_q[CODE_W-2:0]};
    end else begin : g_offset
      assign even_off = even_q;
      assign odd_off  = odd_q;
    end
  endgenerate

  // slow domain: input register, then encoded-word register
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      even_q   <= '0;
      odd_q    <= '0;
      enc_even <= '0;
      enc_odd  <= '0;
      tog      <= 1'b0;
    end else begin
      even_q   <= even_code;
      odd_q    <= odd_code;
      enc_even <= seg_encode(even_off);
      enc_odd  <= seg_encode(odd_off);
      tog      <= ~tog;
    end
  end

  // fast domain: tog differs from its fast copy only at the mid-period edge
  assign mid = tog ^ tog_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      tog_q    <= 1'b0;
      odd_hold <= '0;
      out_word <= '0;
    end else begin
      tog_q <= tog;
      if (mid) begin
        out_word <= odd_hold;
      end else begin
        out_word <= enc_even;
        odd_hold <= enc_odd;
      end
    end
  end

  assign therm_out = out_word[WORD_W-1 -: THERM_W];
  assign bin_out   = out_word[BIN_W-1:0];

endmodule

module dac_seg_serializer_chk #(
  parameter int CODE_W     = 8,
  parameter int UNARY_BITS = 3,
  parameter bit SIGNED_IN  = 1'b1
) (
  input logic                              clk_slow,
  input logic                              clk_fast,
  input logic                              rst_n,
  input logic [CODE_W-1:0]                 even_code,
  input logic [CODE_W-1:0]                 odd_code,
  input logic [(1<<UNARY_BITS)-2:0]        therm_out,
  input logic [CODE_W-UNARY_BITS-1:0]      bin_out
);

  localparam int BIN_W   = CODE_W - UNARY_BITS;
  localparam int THERM_W = (1 << UNARY_BITS) - 1;

  logic [CODE_W-1:0] he0, he1, he2, ho0, ho1, ho2, he2_off, ho2_off;
  logic [1:0]        seen;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      he0 <= '0; he1 <= '0; he2 <= '0;
      ho0 <= '0; ho1 <= '0; ho2 <= '0;
      seen <= '0;
    end else begin
      he0 <= even_code; he1 <= he0; he2 <= he1;
      ho0 <= odd_code;  ho1 <= ho0; ho2 <= ho1;
      if (seen != 2'd3) seen <= seen + 2'd1;
    end
  end

  assign he2_off = SIGNED_IN ? (he2 ^ (CODE_W'(1) << (CODE_W-1))) : he2;
  assign ho2_off = SIGNED_IN ? (ho2 ^ (CODE_W'(1) << (CODE_W-1))) : ho2;

  // R1
  always @(posedge clk_fast)
    if (!rst_n) reset_zero_chk: assert (therm_out == '0 && bin_out == '0);

  // R3
  therm_contig_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    ((therm_out & (therm_out + THERM_W'(1))) == '0));

  // R6
  even_slot_chk: assert property (@(negedge clk_slow) disable iff (!rst_n)
    (seen == 2'd3) |-> (bin_out == he2_off[BIN_W-1:0] &&
                        $countones(therm_out) == int'(he2_off[CODE_W-1 -: UNARY_BITS])));

  // R7
  odd_slot_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (seen == 2'd3) |-> (bin_out == ho2_off[BIN_W-1:0] &&
                        $countones(therm_out) == int'(ho2_off[CODE_W-1 -: UNARY_BITS])));

endmodule

bind dac_seg_serializer dac_seg_serializer_chk #(
  .CODE_W(CODE_W), .UNARY_BITS(UNARY_BITS), .SIGNED_IN(SIGNED_IN)
) u_chk (
  .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
  .even_code(even_code), .odd_code(odd_code),
  .therm_out(therm_out), .bin_out(bin_out)
);

// File: tb/dac_seg_serializer_bench.sv
module dac_seg_serializer_bench;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_n    = 1'b1;
  logic [7:0] ev = 8'h00, od = 8'h00;
  logic [6:0] th_s, th_o;
  logic [4:0] b_s, b_o;

  int n_chk = 0, n_bad = 0, n = 0;
  logic [7:0] cap_ev [0:2047];
  logic [7:0] cap_od [0:2047];

  dac_seg_serializer u_dac_seg_serializer (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .even_code(ev), .odd_code(od), .therm_out(th_s), .bin_out(b_s));

  dac_seg_serializer #(.SIGNED_IN(1'b0)) u_dac_seg_serializer_offs (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .even_code(ev), .odd_code(od), .therm_out(th_o), .bin_out(b_o));

  always #5 clk_fast = ~clk_fast;
  always @(posedge clk_fast) clk_slow <= ~clk_slow;

  function automatic logic [11:0] expect_word(input logic [7:0] code, input bit sgn);
    logic [7:0] off;
    logic [6:0] t;
    off = sgn ? (code ^ 8'h80) : code;
    for (int i = 0; i < 7; i++) t[i] = (int'(off[7:5]) > i);
    return {t, off[4:0]};
  endfunction

  task automatic check_word(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic check_recon(input string req, input logic [6:0] t, input logic [4:0] b,
                             input logic [7:0] code, input bit sgn);
    int got, want;
    got  = $countones(t) * 32 + int'(b);
    want = int'(sgn ? (code ^ 8'h80) : code);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, want);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic [7:0] o);
    @(posedge clk_slow);
    cap_ev[n] = ev;
    cap_od[n] = od;
    #2;
    ev = e;
    od = o;
    #3;
    if (n >= 2) begin
      check_word("R6 R7 R2 R3 R4 even slot", {th_s, b_s}, expect_word(cap_ev[n-2], 1'b1));
      check_recon("R5 even", th_s, b_s, cap_ev[n-2], 1'b1);
      check_word("R8 even offset input", {th_o, b_o}, expect_word(cap_ev[n-2], 1'b0));
    end
    #10;
    if (n >= 2) begin
      check_word("R6 odd slot", {th_s, b_s}, expect_word(cap_od[n-2], 1'b1));
      check_recon("R5 odd", th_s, b_s, cap_od[n-2], 1'b1);
      check_word("R8 odd offset input", {th_o, b_o}, expect_word(cap_od[n-2], 1'b0));
    end
    n++;
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk_fast);
    check_word("R1 reset signed", {th_s, b_s}, 12'h000);
    check_word("R1 reset offset", {th_o, b_o}, 12'h000);
    @(negedge clk_slow);
    #2 rst_n = 1'b1;

    // corners: R2 sign boundaries, R3 all/no lines
    step(8'h00, 8'h80);
    step(8'h7F, 8'hFF);
    step(8'h80, 8'h00);
    step(8'hFF, 8'h7F);
    step(8'h9F, 8'hA0);
    // full sweep of each lane
    for (int i = 0; i < 256; i++) step(8'(i), ~8'(i));
    for (int i = 0; i < 256; i++) step(8'(i * 37), 8'(255 - i));
    // random pairs
    for (int i = 0; i < 300; i++) step(8'($urandom), 8'($urandom));
    // equal lanes
    step(8'h5A, 8'h5A);
    step(8'h00, 8'h00);
    step(8'h00, 8'h00);

    rst_n = 1'b0;
    #3;
    check_word("R1 reset mid-run signed", {th_s, b_s}, 12'h000);
    check_word("R1 reset mid-run offset", {th_o, b_o}, 12'h000);
    finish_up();
  end

endmodule